// File: doc/BRIEF.md
# Parallel Bit-Bang I/O Port

This block drives and samples an 8-bit parallel pin bus on behalf of a host. Bytes arrive on an input stream with valid/ready handshaking. Samples of the pins go back on an output stream that offers one byte per valid pulse, and a space flag from the return buffer gates it. A direction mask makes each pin an output, driven from the last byte applied, or an input, read from the outside world through a two-stage synchronizer.

Two operating codes are recognised. In free-running mode the engine takes one host byte per rate tick and applies it to the pins at once. It returns samples only when a read request is raised. In lockstep mode every byte written produces exactly one sample. The pins are read before the new byte is driven, so each sample shows the state left by the previous byte. A complete-write strobe follows after a setup cycle. Lockstep mode accepts no byte while the return buffer is full. Any other code parks the port, and the pins hold their value.

Top module: `bb_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pin_o` is 0x00, `out_valid_o` is 0, `wr_done_o` is 0 and `in_ready_o` is 0 unless a mode is selected that allows acceptance.
- R2: `pin_oe_o[i]` equals `dir_i[i]`, where 1 means output. In every returned sample, output bits carry the driven value `pin_o[i]` and input bits carry `pin_i[i]` as it stood two clocks before the sampling edge.
- R3: With `mode_i` = 1 (free-running), a byte is accepted only in a cycle where `rate_tick_i` is high. `pin_o` takes that byte at the accepting edge and otherwise holds its last value.
- R4: With `mode_i` = 1, `out_valid_o` is high for one cycle after an edge where `rd_req_i` and `out_space_i` were both high, carrying the sample taken at that edge. No sample is ever emitted otherwise in this mode.
- R5: With `mode_i` = 4 (lockstep), each accepted byte yields exactly one sample, valid in the cycle after the accepting edge. The sample is taken before the byte is driven. With all pins as outputs at 0xFF, writing 0x55, 0xAA, 0xAA returns 0xFF, 0x55, 0xAA.
- R6: With `mode_i` = 4, `in_ready_o` is low while `out_space_i` is low, so no byte is consumed and no sample is produced.
- R7: In lockstep mode, a byte accepted at edge k appears on `pin_o` from edge k+1, and `wr_done_o` is high for exactly the one cycle after edge k+2. `in_ready_o` stays low until edge k+3 has passed.
- R8: For any `mode_i` other than 1 or 4, no byte is accepted, `pin_o` holds, and no sample is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating code: 1 free-running, 4 lockstep, others parked |
| dir_i | input | 8 | Per-pin direction, 1 = output |
| rate_tick_i | input | 1 | Pacing tick for free-running mode |
| rd_req_i | input | 1 | Sample request in free-running mode |
| in_data_i | input | 8 | Host byte |
| in_valid_i | input | 1 | Host byte valid |
| in_ready_o | output | 1 | Host byte accepted this edge when high with valid |
| out_data_o | output | 8 | Returned pin sample |
| out_valid_o | output | 1 | Sample valid, one cycle per sample |
| out_space_i | input | 1 | Return buffer can take a sample |
| pin_i | input | 8 | External pin levels |
| pin_o | output | 8 | Driven pin levels |
| pin_oe_o | output | 8 | Pin output enables |
| wr_done_o | output | 1 | Lockstep write-complete strobe |

## Verification
A lockstep sample is due in the cycle after the accepting edge. The new pin value is due one edge later, the write-complete strobe one edge after that, and ready returns after a further edge. A free-running byte reaches the pins at its accepting edge, and a requested sample is valid one cycle later. The bench drives on falling edges and checks on the following falling edge, one step per edge, so each result is read in exactly the cycle it is due. External pin changes are followed by three idle cycles, so the synchronizer has settled before any sample is expected.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned MODE_W     = 3;
  localparam logic [MODE_W-1:0] MODE_FREE = 3'd1;
  localparam logic [MODE_W-1:0] MODE_LOCK = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_SETUP = 2'd2,
    ST_DONE  = 2'd3
  } step_e;

  function automatic logic [7:0] merge_rb(input logic [7:0] dir,
                                          input logic [7:0] drv,
                                          input logic [7:0] ext);
    return (dir & drv) | (~dir & ext);
  endfunction
endpackage

// File: rtl/bb_pin_sync.sv
module bb_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], d_i[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign q_o[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bb_step_ctrl.sv
module bb_step_ctrl
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rate_tick_i,
  input  logic              rd_req_i,
  input  logic              in_valid_i,
  input  logic              out_space_i,
  output logic              in_ready_o,
  output logic              lock_take_o,
  output logic              free_take_o,
  output logic              drive_load_o,
  output logic              sample_req_o,
  output logic              wr_done_o
);
  step_e state_q, state_d;
  logic  is_free, is_lock, idle;

  always_comb begin
    is_free = (mode_i == MODE_FREE);
    is_lock = (mode_i == MODE_LOCK);
    idle    = (state_q == ST_IDLE);
  end

  always_comb begin
    in_ready_o   = idle && ((is_lock && out_space_i) || (is_free && rate_tick_i));
    lock_take_o  = idle && is_lock && out_space_i && in_valid_i;
    free_take_o  = idle && is_free && rate_tick_i && in_valid_i;
    drive_load_o = (state_q == ST_DRIVE);
    wr_done_o    = (state_q == ST_DONE);
    sample_req_o = lock_take_o || (idle && is_free && rd_req_i && out_space_i);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (lock_take_o) state_d = ST_DRIVE;
      ST_DRIVE: state_d = ST_SETUP;
      ST_SETUP: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R6: lockstep consumption only with room for the sample
  a_r6_space_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lock && in_valid_i && in_ready_o) |-> out_space_i);

  // R8: parked codes never accept
  a_r8_parked_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_free && !is_lock) |-> !in_ready_o);

  // R7: write-complete strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_o |=> !wr_done_o);

  // R7: no new byte accepted while a lockstep step is in flight
  a_r7_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lock_take_o |=> !in_ready_o);
endmodule

// File: rtl/bb_out_latch.sv
module bb_out_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data_i,
  input  logic         lock_take_i,
  input  logic         free_take_i,
  input  logic         drive_load_i,
  output logic [W-1:0] pin_q_o
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] pin_q, pin_d;
  logic         stage_en, pin_en;

  always_comb begin
    stage_en = lock_take_i;
    stage_d  = in_data_i;
    pin_en   = free_take_i || drive_load_i;
    pin_d    = drive_load_i ? stage_q : in_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= '0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_q_o = pin_q;
endmodule

// File: rtl/bb_sample_reg.sv
module bb_sample_reg
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_req_i,
  input  logic [7:0] dir_i,
  input  logic [7:0] drv_i,
  input  logic [7:0] ext_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  logic [7:0] data_q, data_d;
  logic       valid_q;

  always_comb data_d = merge_rb(dir_i, drv_i, ext_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            data_q <= '0;
    else if (sample_req_i) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= sample_req_i;
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/bb_port.sv
module bb_port
  import bb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [7:0]        dir_i,
  input  logic              rate_tick_i,
  input  logic              rd_req_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  input  logic              out_space_i,
  input  logic [7:0]        pin_i,
  output logic [7:0]        pin_o,
  output logic [7:0]        pin_oe_o,
  output logic              wr_done_o
);
  logic [7:0] pin_s;
  logic       lock_take, free_take, drive_load, sample_req;

  bb_pin_sync #(.W(8), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  bb_step_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rate_tick_i(rate_tick_i),
    .rd_req_i(rd_req_i), .in_valid_i(in_valid_i), .out_space_i(out_space_i),
    .in_ready_o(in_ready_o), .lock_take_o(lock_take), .free_take_o(free_take),
    .drive_load_o(drive_load), .sample_req_o(sample_req), .wr_done_o(wr_done_o)
  );

  bb_out_latch #(.W(8)) i_latch (
    .clk(clk), .rst_n(rst_n), .in_data_i(in_data_i), .lock_take_i(lock_take),
    .free_take_i(free_take), .drive_load_i(drive_load), .pin_q_o(pin_o)
  );

  bb_sample_reg i_samp (
    .clk(clk), .rst_n(rst_n), .sample_req_i(sample_req), .dir_i(dir_i),
    .drv_i(pin_o), .ext_i(pin_s), .data_o(out_data_o), .valid_o(out_valid_o)
  );

  assign pin_oe_o = dir_i;

  // R3: driven pins move only on an accepted free-running byte or a lockstep drive step
  a_r3_pin_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_o != $past(pin_o)) |-> $past(free_take || drive_load));

  // R5: each lockstep acceptance yields a sample on the next cycle
  a_r5_sample_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lock_take |=> out_valid_o);

  // R4: a sample is only emitted when the return buffer had room
  a_r4_sample_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(out_space_i));

  // R7: lockstep byte reaches the pins before the write-complete strobe
  a_r7_drive_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    drive_load |=> !wr_done_o);
endmodule

// File: tb/test_bb_port.sv
module test_bb_port;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [2:0] mode;
  logic [7:0] dir, in_data, pin_ext;
  logic       tick, rd_req, in_valid, space;
  logic       in_ready, out_valid, wr_done;
  logic [7:0] out_data, pin_o, pin_oe;

  int total = 0;
  int bad   = 0;
  logic [7:0] cur;

  bb_port i_bb_port (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .rate_tick_i(tick),
    .rd_req_i(rd_req), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_space_i(space), .pin_i(pin_ext), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .wr_done_o(wr_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input logic [7:0] d, input logic [7:0] drv,
                                    input logic [7:0] ext);
    return (d & drv) | (~d & ext);
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // lockstep write: accept, sample, drive, done, ready again
  task automatic lock_write(input logic [7:0] b);
    logic [7:0] exp_s;
    exp_s = rb(dir, cur, pin_ext);
    in_data  = b;
    in_valid = 1'b1;
    #1;
    chk("R6 ready with space", {7'd0, in_ready}, 8'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 sample valid", {7'd0, out_valid}, 8'd1);
    chk("R5 sample lags one byte", out_data, exp_s);
    chk("R2 oe follows dir", pin_oe, dir);
    @(negedge clk);
    chk("R7 pins at k+1", pin_o, b);
    chk("R5 single sample", {7'd0, out_valid}, 8'd0);
    chk("R7 no early done", {7'd0, wr_done}, 8'd0);
    @(negedge clk);
    chk("R7 done at k+2", {7'd0, wr_done}, 8'd1);
    chk("R7 busy", {7'd0, in_ready}, 8'd0);
    @(negedge clk);
    chk("R7 done one cycle", {7'd0, wr_done}, 8'd0);
    cur = b;
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'd0; dir = 8'h00; in_data = 8'h00; pin_ext = 8'h00;
    tick = 1'b0; rd_req = 1'b0; in_valid = 1'b0; space = 1'b1;
    cur = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset pins", pin_o, 8'h00);
    chk("R1 reset valid", {7'd0, out_valid}, 8'd0);
    chk("R1 reset done", {7'd0, wr_done}, 8'd0);
    chk("R1 reset ready", {7'd0, in_ready}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release pins", pin_o, 8'h00);
    chk("R1 after release valid", {7'd0, out_valid}, 8'd0);

    // R5 worked example
    mode = 3'd4; dir = 8'hFF;
    lock_write(8'hFF);
    lock_write(8'h55);
    lock_write(8'hAA);
    lock_write(8'hAA);

    // R2/R5 sweep over masks and all byte values
    foreach (dir[i]) begin end
    for (int m = 0; m < 5; m++) begin
      case (m)
        0: begin dir = 8'hFF; pin_ext = 8'h00; end
        1: begin dir = 8'h00; pin_ext = 8'hA5; end
        2: begin dir = 8'h0F; pin_ext = 8'h3C; end
        3: begin dir = 8'hC3; pin_ext = 8'h5A; end
        default: begin dir = 8'h81; pin_ext = 8'hE7; end
      endcase
      settle();
      for (int v = 0; v < 256; v++) lock_write(8'(v));
    end

    // R6: no space, nothing consumed
    dir = 8'hFF; space = 1'b0; in_data = 8'h12; in_valid = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk("R6 no ready when full", {7'd0, in_ready}, 8'd0);
      @(negedge clk);
      chk("R6 pins held", pin_o, cur);
      chk("R6 no sample", {7'd0, out_valid}, 8'd0);
    end
    in_valid = 1'b0; space = 1'b1;
    @(negedge clk);

    // R3/R4: free-running, tick-paced
    mode = 3'd1; dir = 8'hF0; pin_ext = 8'h69;
    settle();
    for (int v = 0; v < 64; v++) begin
      logic t;
      t = (v % 3) == 0;
      in_data = 8'((v * 37) + 5); in_valid = 1'b1; tick = t;
      #1;
      chk("R3 ready only on tick", {7'd0, in_ready}, {7'd0, t});
      @(negedge clk);
      tick = 1'b0;
      if (t) cur = in_data;
      chk("R3 pins follow tick", pin_o, cur);
      chk("R4 no unrequested sample", {7'd0, out_valid}, 8'd0);
    end
    in_valid = 1'b0;

    // R4: requested samples
    for (int v = 0; v < 16; v++) begin
      logic s;
      s = v[0];
      pin_ext = 8'(v * 17);
      settle();
      rd_req = 1'b1; space = s;
      @(negedge clk);
      rd_req = 1'b0; space = 1'b1;
      chk("R4 sample only with space", {7'd0, out_valid}, {7'd0, s});
      if (s) chk("R2 free readback", out_data, rb(dir, cur, pin_ext));
      @(negedge clk);
      chk("R4 one sample per request", {7'd0, out_valid}, 8'd0);
    end

    // R8: parked codes
    for (int mc = 0; mc < 8; mc++) begin
      if (mc == 1 || mc == 4) continue;
      mode = 3'(mc); in_data = ~cur; in_valid = 1'b1; tick = 1'b1; rd_req = 1'b1;
      #1;
      chk("R8 parked no ready", {7'd0, in_ready}, 8'd0);
      @(negedge clk);
      chk("R8 parked pins hold", pin_o, cur);
      chk("R8 parked no sample", {7'd0, out_valid}, 8'd0);
    end
    in_valid = 1'b0; tick = 1'b0; rd_req = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule